// File: doc/BRIEF.md
# Sync-Locked Ratiometric PWM Sample Encoder

The block sends one signed sample for every half-period of an external SYNC square wave as an active-low pulse on an open-drain line. Both SYNC edges open a new half-cycle. The half-cycle that follows a sample carries that sample as a low pulse at its start. The pulse length is a fraction of the measured length of the half-cycle that held the sample. A receiver that times both the pulse and the preceding half-cycle recovers a duty ratio that does not depend on the SYNC frequency. Zero input gives a ratio of 20 %. The slope is inverted, so full positive scale gives 10 % and full negative scale gives 30 %.

Samples arrive on a valid/ready stream. The encoder takes at most one sample per half-cycle and drops `s_ready` once it holds one, so the producer is held off until the next SYNC edge. A producer may skip a half-cycle; the last sample taken is then sent again.

The block also measures the full SYNC period against the system clock. From that period it derives a two-bit time-constant code for an external integrator. It raises a flag when SYNC leaves the 4 to 20 kHz window or stops. The flag and a fault input both keep the line released.

Top module: `sync_pwm_encoder`

## Requirements
- R1: Every toggle of `sync_in`, rising or falling, opens a new half-cycle. The half-cycle length L is the number of clock cycles between two detected edges. A pulse starts SYNC_STAGES+1 clock edges after the toggle.
- R2: A sample is taken when `s_valid` and `s_ready` are both high at a clock edge. After that, `s_ready` stays low until the next SYNC edge has been detected. A sample taken during half-cycle k is encoded at the start of half-cycle k+1. If no sample was taken, the last one is used again.
- R3: `po_pull` is high for floor(L × (4094 − c) / 20470) consecutive cycles. Here c is the two's-complement sample code (12 bits by default) and L is the length of the half-cycle that held it. Code 0 gives 20 % of L.
- R4: Code +2047 gives 10 % of L and code −2047 gives 30 % of L. Code −2048 is clamped to −2047.
- R5: The division rounds down. For example, L = 45 with code 1 gives 8 cycles, not 9.
- R6: The first SYNC edge after reset has no measured half-cycle before it, so it produces no pulse.
- R7: `gain_sel` (bit 1 is the MSB) is set from the SYNC period P, the sum of the last two half-cycle lengths, in clock cycles. The bounds are F16 = CLK_HZ/16000, F10 = CLK_HZ/10000 and F6 = CLK_HZ/6000. P < F16 gives 2'b11. F16 ≤ P < F10 gives 2'b10. F10 ≤ P < F6 gives 2'b01. Otherwise it gives 2'b00. The code changes only in the cycle after a detected edge, once two half-cycles have been measured.
- R8: While `oc_fault` is high, `po_pull` is low.
- R9: `sync_err` is set in either of two cases. The first is a period outside the window CLK_HZ/20000 ≤ P ≤ CLK_HZ/4000. The second is a half-cycle that runs longer than CLK_HZ/4000 cycles with no edge. The flag clears at the next edge with an in-range period. While it is set, `po_pull` is low.
- R10: After reset, `po_pull` = 0, `s_ready` = 1, `gain_sel` = 2'b00 and `sync_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External SYNC square wave, asynchronous |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready, one acceptance per half-cycle |
| s_code | input | SAMPLE_W | Signed sample code |
| oc_fault | input | 1 | Over-current fault; releases the line while high |
| po_pull | output | 1 | 1 = pull the open-drain line low |
| gain_sel | output | 2 | Integrator time-constant code |
| sync_err | output | 1 | SYNC period out of range or SYNC stopped |

## Verification
A toggle driven on a falling clock edge reaches the edge detector after SYNC_STAGES+1 rising edges. The pulse load, the `gain_sel` update, the `sync_err` update and the reopening of `s_ready` all land on that same rising edge. The bench never checks inside that window. Pulse widths are measured by a monitor that counts consecutive high samples of `po_pull` on falling edges, so the exact start cycle does not affect the result. `gain_sel` and `sync_err` are read at the end of a half-cycle, well after their update edge. `s_ready` is read four cycles after a toggle and one cycle after an accepted transfer.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef enum logic [1:0] {
    GAIN_SLOW = 2'b00,
    GAIN_LOW  = 2'b01,
    GAIN_MID  = 2'b10,
    GAIN_FAST = 2'b11
  } gain_sel_e;
endpackage

// File: rtl/spe_sync_edge.sv
module spe_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  output logic edge_o
);
  // chain[0..STAGES-1] resynchronise, chain[STAGES] is the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], sync_raw};
  end

  assign edge_o = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/spe_period_meter.sv
module spe_period_meter
  import sync_pwm_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int CNT_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic [CNT_W-1:0] len_o,
  output logic             len_ok_o,
  output gain_sel_e        gain_o,
  output logic             err_o
);
  localparam int PER_W = CNT_W + 1;
  localparam logic [PER_W-1:0] P_MIN = PER_W'(CLK_HZ / 20000);
  localparam logic [PER_W-1:0] P_16K = PER_W'(CLK_HZ / 16000);
  localparam logic [PER_W-1:0] P_10K = PER_W'(CLK_HZ / 10000);
  localparam logic [PER_W-1:0] P_6K  = PER_W'(CLK_HZ / 6000);
  localparam logic [PER_W-1:0] P_MAX = PER_W'(CLK_HZ / 4000);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(CLK_HZ / 4000 + 1);

  logic [CNT_W-1:0] hcnt, prev_len;
  logic [1:0]       nedge;
  logic [PER_W-1:0] period;
  gain_sel_e        band;

  assign len_o    = hcnt + 1'b1;
  assign len_ok_o = (nedge != 2'd0);
  assign period   = PER_W'(len_o) + PER_W'(prev_len);

  always_comb begin
    if      (period < P_16K) band = GAIN_FAST;
    else if (period < P_10K) band = GAIN_MID;
    else if (period < P_6K)  band = GAIN_LOW;
    else                     band = GAIN_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      prev_len <= '0;
      nedge    <= '0;
      gain_o   <= GAIN_SLOW;
      err_o    <= 1'b0;
    end else if (edge_i) begin
      hcnt     <= '0;
      prev_len <= len_o;
      if (nedge != 2'd2) nedge <= nedge + 2'd1;
      if (nedge == 2'd2) begin
        gain_o <= band;
        err_o  <= (period < P_MIN) || (period > P_MAX);
      end
    end else if (hcnt != SAT) begin
      hcnt <= hcnt + 1'b1;
    end else begin
      err_o <= 1'b1;  // SYNC stopped
    end
  end
endmodule

// File: rtl/spe_duty_calc.sv
module spe_duty_calc #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 14
) (
  input  logic [CNT_W-1:0]           len_i,
  input  logic signed [SAMPLE_W-1:0] code_i,
  output logic [CNT_W-1:0]           low_o
);
  localparam int FS     = 2 ** (SAMPLE_W - 1) - 1;
  localparam int SL_W   = SAMPLE_W + 2;
  localparam int PROD_W = CNT_W + SL_W;
  localparam logic signed [SAMPLE_W-1:0] C_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] C_NEG = C_MIN + 1'b1;
  localparam logic signed [SL_W-1:0]     TWO_FS = SL_W'(2 * FS);
  localparam logic [PROD_W-1:0]          DEN    = PROD_W'(10 * FS);

  logic signed [SAMPLE_W-1:0] c_cl;
  logic signed [SL_W-1:0]     slope;
  logic [PROD_W-1:0]          prod;

  always_comb begin
    c_cl  = (code_i == C_MIN) ? C_NEG : code_i;
    slope = TWO_FS - {{2{c_cl[SAMPLE_W-1]}}, c_cl};   // in [FS, 3*FS]
    prod  = {{SL_W{1'b0}}, len_i} * {{CNT_W{1'b0}}, slope};
    low_o = CNT_W'(prod / DEN);
  end
endmodule

// File: rtl/spe_pulse_gen.sv
module spe_pulse_gen #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] low_i,
  input  logic             block_i,
  output logic             pull_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= low_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pull_o = (cnt != '0) && !block_i;
endmodule

// File: rtl/sync_pwm_encoder.sv
module sync_pwm_encoder
  import sync_pwm_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SAMPLE_W    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sync_in,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_code,
  input  logic                       oc_fault,
  output logic                       po_pull,
  output logic [1:0]                 gain_sel,
  output logic                       sync_err
);
  localparam int CNT_W = $clog2(CLK_HZ / 4000 + 2);

  logic                       edge_w, len_ok_w, load_w, taken, hs;
  logic [CNT_W-1:0]           len_w, low_w;
  logic signed [SAMPLE_W-1:0] pending;
  gain_sel_e                  gain_e;

  spe_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sync_raw(sync_in), .edge_o(edge_w)
  );

  spe_period_meter #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .len_o(len_w),
    .len_ok_o(len_ok_w), .gain_o(gain_e), .err_o(sync_err)
  );

  // sample stream: one acceptance per half-cycle
  assign s_ready = !taken;
  assign hs      = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken   <= 1'b0;
      pending <= '0;
    end else begin
      if (edge_w)  taken <= hs;
      else if (hs) taken <= 1'b1;
      if (hs) pending <= s_code;
    end
  end

  spe_duty_calc #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_calc (
    .len_i(len_w), .code_i(pending), .low_o(low_w)
  );

  assign load_w = edge_w && len_ok_w;

  spe_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .low_i(low_w),
    .block_i(oc_fault || sync_err), .pull_o(po_pull)
  );

  assign gain_sel = gain_e;
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_i,
  input logic             s_valid,
  input logic             s_ready,
  input logic             oc_fault,
  input logic             sync_err,
  input logic             po_pull,
  input logic [1:0]       gain_sel,
  input logic             load,
  input logic [CNT_W-1:0] low,
  input logic [CNT_W-1:0] len
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen <= 1'b0;
    else if (edge_i) seen <= 1'b1;
  end

  a_r8_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> !po_pull);

  a_r9_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> !po_pull);

  a_r2_one_per_half: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !edge_i) |=> !s_ready);

  a_r7_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_i |=> $stable(gain_sel));

  a_r4_duty_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((int'(low) * 10 <= int'(len) * 3) && (int'(low) * 10 + 10 > int'(len))));

  a_r6_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !seen) |=> !po_pull);
endmodule

bind sync_pwm_encoder spe_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .s_valid(s_valid),
  .s_ready(s_ready), .oc_fault(oc_fault), .sync_err(sync_err),
  .po_pull(po_pull), .gain_sel(gain_sel), .load(load_w), .low(low_w),
  .len(len_w)
);

// File: tb/test_sync_pwm_encoder.sv
module test_sync_pwm_encoder;
  localparam int CLK_HZ = 1_000_000;  // scaled so SYNC periods stay short
  localparam int NV = 11;
  // {half length, code, send, expected low cycles}
  localparam int VEC [NV][4] = '{
    '{50,     0, 1, 10}, '{50,  2047, 1,  5}, '{50, -2047, 1, 15},
    '{60,  1000, 1,  9}, '{60, -1000, 1, 14}, '{40, -2048, 1, 12},
    '{40,   500, 1,  7}, '{55,  -300, 1, 11}, '{45,  2000, 1,  4},
    '{45,     1, 1,  8}, '{50,     0, 0,  9}
  };

  logic clk = 0, rst_n = 0, sync_in = 0, s_valid = 0, oc_fault = 0;
  logic signed [11:0] s_code = '0;
  logic s_ready, po_pull, sync_err;
  logic [1:0] gain_sel;

  int checks = 0, fails = 0, npulse = 0, run = 0;
  int fault_viol = 0, err_viol = 0;
  int widths [64];
  bit done = 0;

  always #10 clk = ~clk;

  sync_pwm_encoder #(.CLK_HZ(CLK_HZ)) i_sync_pwm_encoder (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .s_valid(s_valid),
    .s_ready(s_ready), .s_code(s_code), .oc_fault(oc_fault),
    .po_pull(po_pull), .gain_sel(gain_sel), .sync_err(sync_err)
  );

  always @(negedge clk) begin
    if (po_pull) run++;
    else if (run > 0) begin
      if (npulse < 64) widths[npulse] = run;
      npulse++;
      run = 0;
    end
    if (po_pull && oc_fault) fault_viol++;
    if (po_pull && sync_err) err_viol++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic half(input int h, input int code, input bit send);
    sync_in = ~sync_in;
    for (int k = 1; k < h; k++) begin
      @(negedge clk);
      if (k == 4 && send) begin s_valid = 1; s_code = code[11:0]; end
      if (k == 5) s_valid = 0;
    end
    @(negedge clk);
  endtask

  task automatic halves(input int h, input int n);
    for (int i = 0; i < n; i++) half(h, 0, 1);
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(po_pull == 0, "R10 po_pull", po_pull, 0);
    chk(s_ready == 1, "R10 s_ready", s_ready, 1);
    chk(gain_sel == 2'b00, "R10 gain_sel", gain_sel, 0);
    chk(sync_err == 0, "R10 sync_err", sync_err, 0);

    // vector table: R1 R3 R4 R5 R2 (reuse)
    for (int i = 0; i < NV; i++) begin
      half(VEC[i][0], VEC[i][1], VEC[i][2] != 0);
      if (i == 0) chk(npulse == 0, "R6 no pulse in first half", npulse, 0);
    end
    half(50, 0, 0);
    chk(npulse == NV, "R1 one pulse per half", npulse, NV);
    for (int i = 0; i < NV; i++)
      chk(widths[i] == VEC[i][3], "R3/R4/R5/R2 low width", widths[i], VEC[i][3]);
    chk(sync_err == 0, "R9 in-range no error", sync_err, 0);

    // R7 gain bands, including boundaries
    halves(29, 4); chk(gain_sel == 2'b11, "R7 P=58", gain_sel, 3);
    halves(31, 4); chk(gain_sel == 2'b10, "R7 P=62 boundary", gain_sel, 2);
    halves(40, 4); chk(gain_sel == 2'b10, "R7 P=80", gain_sel, 2);
    halves(50, 4); chk(gain_sel == 2'b01, "R7 P=100 boundary", gain_sel, 1);
    halves(60, 4); chk(gain_sel == 2'b01, "R7 P=120", gain_sel, 1);
    halves(90, 4); chk(gain_sel == 2'b00, "R7 P=180", gain_sel, 0);

    // R9 error window and timeout
    halves(24, 4); chk(sync_err == 1, "R9 too fast", sync_err, 1);
    halves(90, 4); chk(sync_err == 0, "R9 recover", sync_err, 0);
    halves(130, 4); chk(sync_err == 1, "R9 too slow", sync_err, 1);
    halves(90, 4); chk(sync_err == 0, "R9 recover", sync_err, 0);
    repeat (300) @(negedge clk);
    chk(sync_err == 1, "R9 timeout", sync_err, 1);
    halves(50, 4); chk(sync_err == 0, "R9 recover after stop", sync_err, 0);
    chk(err_viol == 0, "R9 released while error", err_viol, 0);

    // R2 ready handshake
    sync_in = ~sync_in;
    repeat (4) @(negedge clk);
    chk(s_ready == 1, "R2 ready open", s_ready, 1);
    s_valid = 1; s_code = 12'sd100;
    @(negedge clk);
    s_valid = 0;
    chk(s_ready == 0, "R2 ready closed", s_ready, 0);
    repeat (44) @(negedge clk);
    chk(s_ready == 0, "R2 ready held", s_ready, 0);
    sync_in = ~sync_in;
    repeat (4) @(negedge clk);
    chk(s_ready == 1, "R2 ready reopened", s_ready, 1);
    repeat (46) @(negedge clk);

    // R8 fault
    oc_fault = 1;
    n0 = npulse;
    halves(40, 4);
    chk(npulse == n0, "R8 no pulse under fault", npulse, n0);
    chk(fault_viol == 0, "R8 released under fault", fault_viol, 0);
    oc_fault = 0;
    halves(40, 3);
    chk(npulse > n0, "R8 pulses resume", npulse - n0, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule